// File: doc/BRIEF.md
# DRAM Command Timing Monitor

This block is a passive observer on a DRAM command stream. At most one command arrives per cycle. Each command is an activate, precharge, read or write, and it names a bank group, a bank within that group and a row. The monitor never drives the stream. It checks every accepted command against the spacing rules and the row-open protocol that any earlier commands impose. When a command breaks a rule, the monitor reports it.

The monitor does not store a command history. For each bank it keeps how long ago the last activate, precharge, read and write took place, plus whether the bank is open and which row is open. For each bank group it keeps the age of the last read and the last write. It also keeps a three-entry window of the most recent activates for the four-activate rule. Every age counter saturates, so long idle periods cost no extra storage. Rules that compare the same bank group against a different bank group use separate long and short limits. The short limits only apply when more than one group exists.

The command input is a valid-only stream. There is no ready signal, because the monitor takes a command in every cycle and never applies back-pressure. The producer sees no stall, and a command held for two cycles with valid high counts as two commands. The violation output is a plain one-cycle pulse.

Top module: `dtc_timing_monitor`

## Requirements
- R1: After reset the violation output is quiet, every bank is closed and no earlier command of any kind is remembered. A read right after reset is therefore reported as a command to a closed bank.
- R2: A command accepted at a rising edge (cmd_valid high) produces its result at that same edge. viol_valid is high for exactly one cycle, and viol_group and viol_bank give the group and bank of the offending command. viol_code is 0 whenever viol_valid is low. When several rules fail at once, the smallest code is reported.
- R3: Row protocol. An activate to an open bank gives code 1. A read or write to a closed bank gives code 2, and it leaves that bank open on the commanded row. A read or write to an open bank whose open row differs gives code 3. A precharge closes the bank.
- R4: Same-bank activate spacing. The gap from the previous activate must be at least T_RC (code 4), and the gap from the previous precharge must be at least T_RP (code 5).
- R5: Activates to different banks must be spaced at least T_RRD_L apart within a group (code 6) and at least T_RRD_S apart across groups (code 7). The cross-group rule applies only when GROUPS > 1.
- R6: When an activate and the three most recent earlier activates all target distinct banks, the oldest of those three must be at least T_FAW cycles old (code 8).
- R7: A read or write must come at least T_RCD after the activate of its bank (code 9).
- R8: Read after read, or write after write, needs at least T_CCD_L within a group (code 10) and at least T_CCD_S across groups (code 11).
- R9: A read after a write needs at least T_WTR_L+T_WL+T_BURST within a group (code 12) and at least T_WTR_S+T_WL+T_BURST across groups (code 13).
- R10: A write after a read to any bank needs at least T_RTW (code 14).
- R11: A precharge needs at least T_RAS after the bank's activate (code 15), at least T_RTP after its last read (code 16), and at least T_WL+T_BURST+T_WR after its last write (code 17).
- R12: The kind encoding is 0 = activate, 1 = precharge, 2 = read, 3 = write. The global bank number is group*BANKS_PER_GROUP+bank. A gap is the number of rising edges between the two accepting edges, and a rule fails when the gap is below its limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_kind | input | 2 | Command kind (R12 encoding) |
| cmd_group | input | GW = max(1, clog2(GROUPS)) | Bank group of the command |
| cmd_bank | input | BW = max(1, clog2(BANKS_PER_GROUP)) | Bank within the group |
| cmd_row | input | ROW_W | Row addressed by activate, read or write |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 5 | Code of the failing rule, 0 when quiet |
| viol_group | output | GW | Group of the offending command |
| viol_bank | output | BW | Bank of the offending command |

## Verification
The hardest condition to reach from the ports is a single rule failing on its own, because one badly placed command usually breaks several rules and the lowest code hides the rest. Two cases need the most care. The four-activate window needs four activates to distinct banks that each meet the pairwise activate spacing but are still too close overall. The cross-group write-to-read rule needs a write and a read whose gap sits between the short and long limits. The stimulus places commands on exact cycle offsets after a fresh reset and holds idle cycles in between so that only the intended rule is short. A table-driven sequence also stacks deliberate collisions to check that the smallest code wins.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_PRE = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } dtc_cmd_e;

  // Lower value wins when several rules fail on the same command.
  typedef enum logic [4:0] {
    RULE_NONE       = 5'd0,
    RULE_ACT_OPEN   = 5'd1,
    RULE_CAS_CLOSED = 5'd2,
    RULE_ROW_MISS   = 5'd3,
    RULE_RC         = 5'd4,
    RULE_RP         = 5'd5,
    RULE_RRD_L      = 5'd6,
    RULE_RRD_S      = 5'd7,
    RULE_FAW        = 5'd8,
    RULE_RCD        = 5'd9,
    RULE_CCD_L      = 5'd10,
    RULE_CCD_S      = 5'd11,
    RULE_WTR_L      = 5'd12,
    RULE_WTR_S      = 5'd13,
    RULE_RTW        = 5'd14,
    RULE_RAS        = 5'd15,
    RULE_RTP        = 5'd16,
    RULE_WREC       = 5'd17
  } dtc_rule_e;

endpackage

// File: rtl/dtc_age.sv
// Saturating elapsed-cycle counter: reads 1 one edge after the event.
module dtc_age #(
  parameter int CW  = 6,
  parameter int SAT = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  output logic          seen,
  output logic [CW-1:0] age
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      age  <= '0;
    end else if (hit) begin
      seen <= 1'b1;
      age  <= CW'(1);
    end else if (seen && age < SAT_V) begin
      age <= age + CW'(1);
    end
  end
endmodule

// File: rtl/dtc_bank_track.sv
module dtc_bank_track
  import dtc_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int CW    = 6,
  parameter int SAT   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  dtc_cmd_e         kind,
  input  logic [ROW_W-1:0] row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_seen,
  output logic [CW-1:0]    act_age,
  output logic             pre_seen,
  output logic [CW-1:0]    pre_age,
  output logic             rd_seen,
  output logic [CW-1:0]    rd_age,
  output logic             wr_seen,
  output logic [CW-1:0]    wr_age
);
  logic hit_act, hit_pre, hit_rd, hit_wr;
  assign hit_act = sel && kind == CMD_ACT;
  assign hit_pre = sel && kind == CMD_PRE;
  assign hit_rd  = sel && kind == CMD_RD;
  assign hit_wr  = sel && kind == CMD_WR;

  dtc_age #(.CW(CW), .SAT(SAT)) u_act (.clk(clk), .rst_n(rst_n), .hit(hit_act), .seen(act_seen), .age(act_age));
  dtc_age #(.CW(CW), .SAT(SAT)) u_pre (.clk(clk), .rst_n(rst_n), .hit(hit_pre), .seen(pre_seen), .age(pre_age));
  dtc_age #(.CW(CW), .SAT(SAT)) u_rd  (.clk(clk), .rst_n(rst_n), .hit(hit_rd),  .seen(rd_seen),  .age(rd_age));
  dtc_age #(.CW(CW), .SAT(SAT)) u_wr  (.clk(clk), .rst_n(rst_n), .hit(hit_wr),  .seen(wr_seen),  .age(wr_age));

  // A column access to a closed bank is flagged upstream but still opens the
  // bank, so a later activate without precharge is caught as well.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (hit_act) begin
      is_open  <= 1'b1;
      open_row <= row;
    end else if (hit_pre) begin
      is_open  <= 1'b0;
    end else if ((hit_rd || hit_wr) && !is_open) begin
      is_open  <= 1'b1;
      open_row <= row;
    end
  end
endmodule

// File: rtl/dtc_faw_window.sv
// Holds the most recent activates (bank and age), newest in slot 0.
module dtc_faw_window #(
  parameter int DEPTH = 3,
  parameter int IW    = 2,
  parameter int CW    = 6,
  parameter int SAT   = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_bank,
  output logic          ent_v    [DEPTH],
  output logic [IW-1:0] ent_bank [DEPTH],
  output logic [CW-1:0] ent_age  [DEPTH]
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] a);
    return (a < SAT_V) ? a + CW'(1) : a;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_v[i]    <= 1'b0;
          ent_bank[i] <= '0;
          ent_age[i]  <= '0;
        end else if (push) begin
          ent_v[i]    <= 1'b1;
          ent_bank[i] <= push_bank;
          ent_age[i]  <= CW'(1);
        end else begin
          ent_age[i]  <= bump(ent_age[i]);
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_v[i]    <= 1'b0;
          ent_bank[i] <= '0;
          ent_age[i]  <= '0;
        end else if (push) begin
          ent_v[i]    <= ent_v[i-1];
          ent_bank[i] <= ent_bank[i-1];
          ent_age[i]  <= bump(ent_age[i-1]);
        end else begin
          ent_age[i]  <= bump(ent_age[i]);
        end
      end
    end
  end
endmodule

// File: rtl/dtc_timing_monitor.sv
module dtc_timing_monitor
  import dtc_pkg::*;
#(
  parameter int GROUPS          = 2,
  parameter int BANKS_PER_GROUP = 2,
  parameter int ROW_W           = 8,
  parameter int T_RRD_S = 2,
  parameter int T_RRD_L = 3,
  parameter int T_FAW   = 10,
  parameter int T_RC    = 8,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 5,
  parameter int T_RTP   = 2,
  parameter int T_WR    = 2,
  parameter int T_WL    = 2,
  parameter int T_BURST = 2,
  parameter int T_RTW   = 4,
  parameter int T_WTR_S = 1,
  parameter int T_WTR_L = 3,
  parameter int T_CCD_S = 2,
  parameter int T_CCD_L = 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int BW = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [GW-1:0]    cmd_group,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [ROW_W-1:0] cmd_row,
  output logic             viol_valid,
  output logic [4:0]       viol_code,
  output logic [GW-1:0]    viol_group,
  output logic [BW-1:0]    viol_bank
);
  localparam int NB    = GROUPS * BANKS_PER_GROUP;
  localparam int IW    = (NB > 1) ? $clog2(NB) : 1;
  localparam bit MULTI = (GROUPS > 1);
  localparam int DEPTH = 3;
  localparam int SAT   = T_RRD_S + T_RRD_L + T_FAW + T_RC + T_RP + T_RCD + T_RAS
                       + T_RTP + T_WR + T_WL + T_BURST + T_RTW + T_WTR_S + T_WTR_L
                       + T_CCD_S + T_CCD_L;
  localparam int CW    = $clog2(SAT + 2);

  localparam logic [CW-1:0] K_RRD_S = CW'(T_RRD_S);
  localparam logic [CW-1:0] K_RRD_L = CW'(T_RRD_L);
  localparam logic [CW-1:0] K_FAW   = CW'(T_FAW);
  localparam logic [CW-1:0] K_RC    = CW'(T_RC);
  localparam logic [CW-1:0] K_RP    = CW'(T_RP);
  localparam logic [CW-1:0] K_RCD   = CW'(T_RCD);
  localparam logic [CW-1:0] K_RAS   = CW'(T_RAS);
  localparam logic [CW-1:0] K_RTP   = CW'(T_RTP);
  localparam logic [CW-1:0] K_WREC  = CW'(T_WL + T_BURST + T_WR);
  localparam logic [CW-1:0] K_RTW   = CW'(T_RTW);
  localparam logic [CW-1:0] K_WTR_S = CW'(T_WTR_S + T_WL + T_BURST);
  localparam logic [CW-1:0] K_WTR_L = CW'(T_WTR_L + T_WL + T_BURST);
  localparam logic [CW-1:0] K_CCD_S = CW'(T_CCD_S);
  localparam logic [CW-1:0] K_CCD_L = CW'(T_CCD_L);
  localparam logic [IW-1:0] BPG_V   = IW'(BANKS_PER_GROUP);

  dtc_cmd_e      kind;
  logic [IW-1:0] cur_idx;
  logic is_act, is_pre, is_rd, is_wr, is_cas;

  assign kind    = dtc_cmd_e'(cmd_kind);
  assign cur_idx = IW'(cmd_group) * BPG_V + IW'(cmd_bank);
  assign is_act  = cmd_valid && kind == CMD_ACT;
  assign is_pre  = cmd_valid && kind == CMD_PRE;
  assign is_rd   = cmd_valid && kind == CMD_RD;
  assign is_wr   = cmd_valid && kind == CMD_WR;
  assign is_cas  = is_rd || is_wr;

  // Per-bank state
  logic             b_open     [NB];
  logic [ROW_W-1:0] b_row      [NB];
  logic             b_act_seen [NB];
  logic [CW-1:0]    b_act_age  [NB];
  logic             b_pre_seen [NB];
  logic [CW-1:0]    b_pre_age  [NB];
  logic             b_rd_seen  [NB];
  logic [CW-1:0]    b_rd_age   [NB];
  logic             b_wr_seen  [NB];
  logic [CW-1:0]    b_wr_age   [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    dtc_bank_track #(.ROW_W(ROW_W), .CW(CW), .SAT(SAT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (cmd_valid && cur_idx == IW'(b)),
      .kind     (kind),
      .row      (cmd_row),
      .is_open  (b_open[b]),
      .open_row (b_row[b]),
      .act_seen (b_act_seen[b]),
      .act_age  (b_act_age[b]),
      .pre_seen (b_pre_seen[b]),
      .pre_age  (b_pre_age[b]),
      .rd_seen  (b_rd_seen[b]),
      .rd_age   (b_rd_age[b]),
      .wr_seen  (b_wr_seen[b]),
      .wr_age   (b_wr_age[b])
    );
  end

  // Per-group column history
  logic          g_rd_seen [GROUPS];
  logic [CW-1:0] g_rd_age  [GROUPS];
  logic          g_wr_seen [GROUPS];
  logic [CW-1:0] g_wr_age  [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    dtc_age #(.CW(CW), .SAT(SAT)) u_rd (
      .clk(clk), .rst_n(rst_n), .hit(is_rd && cmd_group == GW'(g)),
      .seen(g_rd_seen[g]), .age(g_rd_age[g]));
    dtc_age #(.CW(CW), .SAT(SAT)) u_wr (
      .clk(clk), .rst_n(rst_n), .hit(is_wr && cmd_group == GW'(g)),
      .seen(g_wr_seen[g]), .age(g_wr_age[g]));
  end

  // Activate window
  logic          w_v    [DEPTH];
  logic [IW-1:0] w_bank [DEPTH];
  logic [CW-1:0] w_age  [DEPTH];

  dtc_faw_window #(.DEPTH(DEPTH), .IW(IW), .CW(CW), .SAT(SAT)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (is_act),
    .push_bank (cur_idx),
    .ent_v     (w_v),
    .ent_bank  (w_bank),
    .ent_age   (w_age)
  );

  // Rule evaluation
  logic f_act_open, f_cas_closed, f_row_miss, f_rc, f_rp, f_rcd;
  logic f_ras, f_rtp, f_wrec, f_rrd_l, f_rrd_s, f_faw;
  logic f_ccd_l, f_ccd_s, f_wtr_l, f_wtr_s, f_rtw;
  logic win_full, win_distinct;
  dtc_rule_e rule;

  always_comb begin
    f_act_open   = is_act && b_open[cur_idx];
    f_cas_closed = is_cas && !b_open[cur_idx];
    f_row_miss   = is_cas && b_open[cur_idx] && b_row[cur_idx] != cmd_row;
    f_rc   = is_act && b_act_seen[cur_idx] && b_act_age[cur_idx] < K_RC;
    f_rp   = is_act && b_pre_seen[cur_idx] && b_pre_age[cur_idx] < K_RP;
    f_rcd  = is_cas && b_act_seen[cur_idx] && b_act_age[cur_idx] < K_RCD;
    f_ras  = is_pre && b_act_seen[cur_idx] && b_act_age[cur_idx] < K_RAS;
    f_rtp  = is_pre && b_rd_seen[cur_idx]  && b_rd_age[cur_idx]  < K_RTP;
    f_wrec = is_pre && b_wr_seen[cur_idx]  && b_wr_age[cur_idx]  < K_WREC;

    f_rrd_l = 1'b0;
    f_rrd_s = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (is_act && IW'(b) != cur_idx && b_act_seen[b]) begin
        if (GW'(b / BANKS_PER_GROUP) == cmd_group) begin
          if (b_act_age[b] < K_RRD_L) f_rrd_l = 1'b1;
        end else if (MULTI) begin
          if (b_act_age[b] < K_RRD_S) f_rrd_s = 1'b1;
        end
      end
    end

    f_ccd_l = 1'b0;
    f_ccd_s = 1'b0;
    f_wtr_l = 1'b0;
    f_wtr_s = 1'b0;
    f_rtw   = 1'b0;
    for (int g = 0; g < GROUPS; g++) begin
      if (GW'(g) == cmd_group) begin
        if (is_rd && g_rd_seen[g] && g_rd_age[g] < K_CCD_L) f_ccd_l = 1'b1;
        if (is_wr && g_wr_seen[g] && g_wr_age[g] < K_CCD_L) f_ccd_l = 1'b1;
        if (is_rd && g_wr_seen[g] && g_wr_age[g] < K_WTR_L) f_wtr_l = 1'b1;
      end else if (MULTI) begin
        if (is_rd && g_rd_seen[g] && g_rd_age[g] < K_CCD_S) f_ccd_s = 1'b1;
        if (is_wr && g_wr_seen[g] && g_wr_age[g] < K_CCD_S) f_ccd_s = 1'b1;
        if (is_rd && g_wr_seen[g] && g_wr_age[g] < K_WTR_S) f_wtr_s = 1'b1;
      end
      if (is_wr && g_rd_seen[g] && g_rd_age[g] < K_RTW) f_rtw = 1'b1;
    end

    win_full     = 1'b1;
    win_distinct = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (!w_v[i]) win_full = 1'b0;
      if (w_bank[i] == cur_idx) win_distinct = 1'b0;
      for (int j = i + 1; j < DEPTH; j++) begin
        if (w_bank[i] == w_bank[j]) win_distinct = 1'b0;
      end
    end
    f_faw = is_act && win_full && win_distinct && w_age[DEPTH-1] < K_FAW;

    if      (f_act_open)   rule = RULE_ACT_OPEN;
    else if (f_cas_closed) rule = RULE_CAS_CLOSED;
    else if (f_row_miss)   rule = RULE_ROW_MISS;
    else if (f_rc)         rule = RULE_RC;
    else if (f_rp)         rule = RULE_RP;
    else if (f_rrd_l)      rule = RULE_RRD_L;
    else if (f_rrd_s)      rule = RULE_RRD_S;
    else if (f_faw)        rule = RULE_FAW;
    else if (f_rcd)        rule = RULE_RCD;
    else if (f_ccd_l)      rule = RULE_CCD_L;
    else if (f_ccd_s)      rule = RULE_CCD_S;
    else if (f_wtr_l)      rule = RULE_WTR_L;
    else if (f_wtr_s)      rule = RULE_WTR_S;
    else if (f_rtw)        rule = RULE_RTW;
    else if (f_ras)        rule = RULE_RAS;
    else if (f_rtp)        rule = RULE_RTP;
    else if (f_wrec)       rule = RULE_WREC;
    else                   rule = RULE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_code  <= 5'd0;
      viol_group <= '0;
      viol_bank  <= '0;
    end else if (rule != RULE_NONE) begin
      viol_valid <= 1'b1;
      viol_code  <= rule;
      viol_group <= cmd_group;
      viol_bank  <= cmd_bank;
    end else begin
      viol_valid <= 1'b0;
      viol_code  <= 5'd0;
      viol_group <= '0;
      viol_bank  <= '0;
    end
  end
endmodule

// File: rtl/dtc_timing_monitor_chk.sv
module dtc_timing_monitor_chk #(
  parameter int GROUPS          = 2,
  parameter int BANKS_PER_GROUP = 2,
  parameter int T_RRD_S         = 2,
  parameter int T_RRD_L         = 3,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int BW = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_kind,
  input logic [GW-1:0] cmd_group,
  input logic [BW-1:0] cmd_bank,
  input logic          viol_valid,
  input logic [4:0]    viol_code,
  input logic [GW-1:0] viol_group,
  input logic [BW-1:0] viol_bank
);
  localparam int NB = GROUPS * BANKS_PER_GROUP;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [IW-1:0] idx;
  logic          prev_act;
  logic [IW-1:0] prev_idx;

  assign idx = IW'(cmd_group) * IW'(BANKS_PER_GROUP) + IW'(cmd_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_act <= 1'b0;
      prev_idx <= '0;
    end else begin
      prev_act <= cmd_valid && cmd_kind == 2'd0;
      prev_idx <= idx;
    end
  end

  // R2
  viol_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(cmd_valid));

  // R2
  quiet_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_valid |-> viol_code == 5'd0);

  // R2
  viol_location_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (viol_group == $past(cmd_group) && viol_bank == $past(cmd_bank)));

  // R3
  act_open_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_code == 5'd1) |-> $past(cmd_kind) == 2'd0);

  // R3
  cas_rule_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && (viol_code == 5'd2 || viol_code == 5'd3)) |-> $past(cmd_kind[1]));

  // R11
  pre_rule_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_code >= 5'd15) |-> $past(cmd_kind) == 2'd1);

  // R5
  adjacent_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD_S > 1 && T_RRD_L > 1 && cmd_valid && cmd_kind == 2'd0 && prev_act && prev_idx != idx)
      |=> viol_valid);
endmodule

bind dtc_timing_monitor dtc_timing_monitor_chk #(
  .GROUPS(GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP),
  .T_RRD_S(T_RRD_S), .T_RRD_L(T_RRD_L)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_group(cmd_group), .cmd_bank(cmd_bank), .viol_valid(viol_valid),
  .viol_code(viol_code), .viol_group(viol_group), .viol_bank(viol_bank)
);

// File: tb/tb_dtc_timing_monitor.sv
module tb_dtc_timing_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic       cmd_group = 1'b0;
  logic       cmd_bank = 1'b0;
  logic [7:0] cmd_row = 8'd0;
  logic       viol_valid;
  logic [4:0] viol_code;
  logic       viol_group;
  logic       viol_bank;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dtc_timing_monitor dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_group(cmd_group), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .viol_valid(viol_valid), .viol_code(viol_code),
    .viol_group(viol_group), .viol_bank(viol_bank)
  );

  localparam logic [1:0] A = 2'd0, P = 2'd1, RD = 2'd2, WR = 2'd3;

  // {valid, kind, group, bank, row, expected code}; one entry per cycle.
  localparam int NT = 20;
  localparam logic [17:0] TBL [NT] = '{
    {1'b1, A,  1'b0, 1'b0, 8'd5, 5'd0},   // 0  R12 first activate
    {1'b1, A,  1'b0, 1'b1, 8'd1, 5'd6},   // 1  R5 same-group activate gap 1
    {1'b1, RD, 1'b0, 1'b0, 8'd5, 5'd9},   // 2  R7 read 2 after activate
    {1'b0, A,  1'b0, 1'b0, 8'd0, 5'd0},   // 3  R2 idle
    {1'b1, A,  1'b1, 1'b0, 8'd2, 5'd0},   // 4  R5 cross-group gaps 4 and 3
    {1'b1, RD, 1'b0, 1'b0, 8'd5, 5'd10},  // 5  R8 same-group reads gap 3
    {1'b1, RD, 1'b1, 1'b0, 8'd2, 5'd9},   // 6  R7 beats R8 short rule
    {1'b1, WR, 1'b0, 1'b1, 8'd1, 5'd14},  // 7  R10 write 1 after read
    {1'b1, RD, 1'b0, 1'b1, 8'd1, 5'd10},  // 8  R8 beats R9
    {1'b0, A,  1'b0, 1'b0, 8'd0, 5'd0},   // 9  R2 idle
    {1'b0, A,  1'b0, 1'b0, 8'd0, 5'd0},   // 10 R2 idle
    {1'b0, A,  1'b0, 1'b0, 8'd0, 5'd0},   // 11 R2 idle
    {1'b0, A,  1'b0, 1'b0, 8'd0, 5'd0},   // 12 R2 idle
    {1'b1, RD, 1'b1, 1'b0, 8'd2, 5'd0},   // 13 R9 cross-group gap 6 legal
    {1'b1, RD, 1'b0, 1'b0, 8'd9, 5'd3},   // 14 R3 wrong row
    {1'b1, P,  1'b0, 1'b0, 8'd0, 5'd16},  // 15 R11 precharge 1 after read
    {1'b1, RD, 1'b0, 1'b0, 8'd5, 5'd2},   // 16 R3 read on closed bank
    {1'b1, A,  1'b0, 1'b0, 8'd5, 5'd1},   // 17 R3 bank reopened by read
    {1'b1, P,  1'b0, 1'b0, 8'd0, 5'd15},  // 18 R11 precharge 1 after activate
    {1'b1, A,  1'b0, 1'b0, 8'd3, 5'd4}    // 19 R4 activate spacing beats R4 precharge gap
  };
  localparam int TREQ [NT] = '{12, 5, 7, 2, 5, 8, 7, 10, 8, 2, 2, 2, 2, 9, 3, 11, 3, 3, 11, 4};

  task automatic step(input logic v, input logic [1:0] k, input logic g,
                      input logic b, input logic [7:0] r, input int ecode,
                      input int req);
    cmd_valid = v; cmd_kind = k; cmd_group = g; cmd_bank = b; cmd_row = r;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (viol_valid !== (ecode != 0) || viol_code !== 5'(ecode)) begin
      errors++;
      $display("FAIL R%0d: valid=%0b code=%0d expected valid=%0b code=%0d",
               req, viol_valid, viol_code, (ecode != 0), ecode);
    end
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) step(1'b0, A, 1'b0, 1'b0, 8'd0, 0, req);
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 quiet outputs in reset
    if (viol_valid !== 1'b0 || viol_code !== 5'd0) begin
      errors++;
      $display("FAIL R1: valid=%0b code=%0d expected valid=0 code=0", viol_valid, viol_code);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    idle(1, 1);

    for (int i = 0; i < NT; i++) begin
      step(TBL[i][17], TBL[i][16:15], TBL[i][14], TBL[i][13], TBL[i][12:5],
           int'(TBL[i][4:0]), TREQ[i]);
    end

    // R1: reset forgets the open banks, so a read is on a closed bank
    do_reset();
    step(1'b1, RD, 1'b0, 1'b0, 8'd5, 2, 1);

    // R6: four distinct activates inside the window
    do_reset();
    step(1'b1, A, 1'b0, 1'b0, 8'd1, 0, 6); idle(1, 6);
    step(1'b1, A, 1'b1, 1'b0, 8'd1, 0, 6); idle(1, 6);
    step(1'b1, A, 1'b0, 1'b1, 8'd1, 0, 6); idle(1, 6);
    step(1'b1, A, 1'b1, 1'b1, 8'd1, 8, 6);

    // R6: fourth activate exactly at the window limit is legal
    do_reset();
    step(1'b1, A, 1'b0, 1'b0, 8'd1, 0, 6); idle(1, 6);
    step(1'b1, A, 1'b1, 1'b0, 8'd1, 0, 6); idle(1, 6);
    step(1'b1, A, 1'b0, 1'b1, 8'd1, 0, 6); idle(5, 6);
    step(1'b1, A, 1'b1, 1'b1, 8'd1, 0, 6);

    // R11: write recovery (limit 6) with precharge at gap 5
    do_reset();
    step(1'b1, A,  1'b0, 1'b0, 8'd4, 0, 11); idle(2, 11);
    step(1'b1, WR, 1'b0, 1'b0, 8'd4, 0, 11); idle(4, 11);
    step(1'b1, P,  1'b0, 1'b0, 8'd0, 17, 11);

    // R9: cross-group read 4 after write (limit 5)
    do_reset();
    step(1'b1, A,  1'b0, 1'b0, 8'd4, 0, 9); idle(2, 9);
    step(1'b1, A,  1'b1, 1'b0, 8'd6, 0, 9); idle(2, 9);
    step(1'b1, WR, 1'b0, 1'b0, 8'd4, 0, 9); idle(3, 9);
    step(1'b1, RD, 1'b1, 1'b0, 8'd6, 13, 9);

    // R9: same-group read 6 after write (limit 7)
    do_reset();
    step(1'b1, A,  1'b0, 1'b0, 8'd4, 0, 9); idle(2, 9);
    step(1'b1, A,  1'b0, 1'b1, 8'd6, 0, 9); idle(2, 9);
    step(1'b1, WR, 1'b0, 1'b0, 8'd4, 0, 9); idle(5, 9);
    step(1'b1, RD, 1'b0, 1'b1, 8'd6, 12, 9);

    // R5: cross-group activates one cycle apart
    do_reset();
    step(1'b1, A, 1'b0, 1'b0, 8'd1, 0, 5);
    step(1'b1, A, 1'b1, 1'b0, 8'd1, 7, 5);

    // R8: cross-group reads one cycle apart, and R2 location report
    do_reset();
    step(1'b1, A,  1'b0, 1'b0, 8'd4, 0, 8); idle(2, 8);
    step(1'b1, A,  1'b1, 1'b0, 8'd6, 0, 8); idle(2, 8);
    step(1'b1, RD, 1'b0, 1'b0, 8'd4, 0, 8);
    step(1'b1, RD, 1'b1, 1'b0, 8'd6, 11, 8);
    checks++;
    if (viol_group !== 1'b1 || viol_bank !== 1'b0) begin
      errors++;
      $display("FAIL R2: group=%0d bank=%0d expected group=1 bank=0", viol_group, viol_bank);
    end
    idle(1, 2);  // R2 pulse lasts one cycle

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule